// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits next to one processor and decides which single external interrupt, if any, is put in front of it. It holds a current processor priority, one pending source with its priority, and a software-set priority for an inter-processor interrupt (IPI). Priorities are inverted: a smaller number is more urgent, and the all-ones value means "nothing". When a better request arrives, it preempts the pending one, and the pending one is handed back to its source as a reject. Software takes an interrupt with an accept, which also raises the processor priority. It finishes the interrupt with an end-of-interrupt (EOI) write, and it can lower or raise its priority at any time. Several of these actions ask the sources to send their held requests again, through a resend pulse.

On the processor side the block has an accept strobe with a captured result word, an EOI write, a priority write, an IPI-priority write, and a continuous poll view of the state. On the source side it takes a request (source number and priority) and drives a reject, an EOI and a resend pulse. All state changes and output pulses appear on the clock edge that follows the operation.

Top module: `intr_presenter`

## Requirements
- R1: The state word is {processor priority[31:24], pending source[23:0]}. A source field of zero means nothing is pending. `poll_word` and `poll_ipi` show the state word and the IPI priority at all times and change nothing. Every operation takes effect, and its output pulses appear, one cycle after it is presented.
- R2: After reset the state word is 0x00000000, the IPI priority and the pending priority are 0xFF, `irq_out` is low, and no pulse output is active.
- R3: A request is rejected, with `rej_src` equal to its source, if its priority is >= the processor priority, or if a source is pending whose priority is <= the request's priority. In that case the state does not change.
- R4: A request that is not rejected rejects the currently pending external source, if there is one. It then becomes pending with its own priority and raises `irq_out`.
- R5: Writing the IPI priority stores the value. If the value is below the processor priority and no pending source has a priority <= the value, source number 2 becomes pending at that priority, `irq_out` rises, and any pending external source is rejected. A pending IPI that is displaced is never reported on the reject output.
- R6: An accept returns the old state word on `acc_word` with `acc_valid`. It drops `irq_out`, moves the pending priority into the processor priority, clears the source field and sets the pending priority to 0xFF.
- R7: A priority write stores the new processor priority. If the new value is lower than the old one, something is pending, and the new value is <= the pending priority, then the pending source is cleared, `irq_out` drops and the source is rejected (an IPI is not rejected).
- R8: A priority write that keeps or raises the priority while nothing is pending triggers a resend. A resend pulses `resend_req`. When the IPI priority is below the new processor priority, the resend first makes the IPI pending.
- R9: An EOI write loads the processor priority from bits 31:24 and puts bits 23:0 on `eoi_src` with `eoi_valid`. If nothing is pending, it also triggers a resend as in R8.
- R10: Only one processor operation runs per cycle, in the order accept, EOI, priority write, IPI-priority write. The operations that lose in the same cycle are ignored.
- R11: A request that arrives together with a processor operation is held and is handled in the first following cycle with no processor operation.
- R12: `irq_out` is high exactly when the source field of the state word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_accept | input | 1 | Accept (read and acknowledge) strobe |
| acc_valid | output | 1 | Accept result valid |
| acc_word | output | 32 | State word captured by the accept |
| cpu_eoi_we | input | 1 | EOI write strobe |
| cpu_eoi_word | input | 32 | EOI write data: new priority and finished source |
| cpu_prio_we | input | 1 | Processor priority write strobe |
| cpu_prio_val | input | 8 | New processor priority |
| cpu_ipi_we | input | 1 | IPI priority write strobe |
| cpu_ipi_val | input | 8 | New IPI priority |
| poll_word | output | 32 | Current state word |
| poll_ipi | output | 8 | Current IPI priority |
| req_valid | input | 1 | Source request strobe |
| req_src | input | 24 | Requesting source number |
| req_prio | input | 8 | Requesting priority |
| rej_valid | output | 1 | Reject pulse to the sources |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | EOI pulse to the sources |
| eoi_src | output | 24 | Source number being finished |
| resend_req | output | 1 | Resend pulse to the sources |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The bench covers a few cases that are easy to get wrong:
- Equal priorities must reject. A design that compares with a strict less-than would let an equal request replace the pending one.
- An IPI that is preempted, or cleared by a lower priority, must produce no reject pulse. A design without ownership tracking would send source 2 back to the sources.
- An IPI-priority write that is not more urgent than the pending source must leave the state word as it is.
- A resend after an EOI or a priority raise must bring the IPI back in.
- An accept that coincides with an IPI-priority write must keep the IPI priority unchanged.
- A request that coincides with a priority write must appear one cycle later instead of being lost.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_ACCEPT = 3'd1,
    OP_EOI    = 3'd2,
    OP_PRIO   = 3'd3,
    OP_IPI    = 3'd4,
    OP_REQ    = 3'd5
  } ipc_op_e;
endpackage

// File: rtl/ipc_arb.sv
module ipc_arb
  import ipc_pkg::*;
#(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_accept,
  input  logic              cpu_eoi_we,
  input  logic              cpu_prio_we,
  input  logic              cpu_ipi_we,
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [PRIO_W-1:0] req_prio,
  output ipc_op_e           op,
  output logic [SRC_W-1:0]  eff_src,
  output logic [PRIO_W-1:0] eff_prio
);
  logic              hold_vld_q, hold_vld_d;
  logic [SRC_W-1:0]  hold_src_q, hold_src_d;
  logic [PRIO_W-1:0] hold_prio_q, hold_prio_d;
  logic              hold_ld;
  logic              cpu_any, eff_vld;

  assign cpu_any  = cpu_accept | cpu_eoi_we | cpu_prio_we | cpu_ipi_we;
  assign eff_vld  = hold_vld_q | req_valid;
  assign eff_src  = hold_vld_q ? hold_src_q  : req_src;
  assign eff_prio = hold_vld_q ? hold_prio_q : req_prio;

  // fixed processor-side order, a source request only when the processor is idle
  always_comb begin
    if (cpu_accept)       op = OP_ACCEPT;
    else if (cpu_eoi_we)  op = OP_EOI;
    else if (cpu_prio_we) op = OP_PRIO;
    else if (cpu_ipi_we)  op = OP_IPI;
    else if (eff_vld)     op = OP_REQ;
    else                  op = OP_NONE;
  end

  // one-deep slot for a request that loses to a processor operation
  always_comb begin
    hold_ld     = 1'b0;
    hold_src_d  = hold_src_q;
    hold_prio_d = hold_prio_q;
    if (cpu_any) begin
      hold_vld_d  = eff_vld;
      hold_ld     = eff_vld;
      hold_src_d  = eff_src;
      hold_prio_d = eff_prio;
    end else if (hold_vld_q && req_valid) begin
      hold_vld_d  = 1'b1;
      hold_ld     = 1'b1;
      hold_src_d  = req_src;
      hold_prio_d = req_prio;
    end else begin
      hold_vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q  <= 1'b0;
      hold_src_q  <= '0;
      hold_prio_q <= '0;
    end else begin
      hold_vld_q <= hold_vld_d;
      if (hold_ld) begin
        hold_src_q  <= hold_src_d;
        hold_prio_q <= hold_prio_d;
      end
    end
  end
endmodule

// File: rtl/ipc_ipi_eval.sv
module ipc_ipi_eval #(
  parameter int PRIO_W = 8
) (
  input  logic              check_en,
  input  logic              pend_nz,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] ipi_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  output logic              ipi_take
);
  logic below_cur, blocked;

  assign below_cur = ipi_prio < cur_prio;
  assign blocked   = pend_nz && (pend_prio <= ipi_prio);
  assign ipi_take  = check_en && below_cur && !blocked;
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
  import ipc_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_accept,
  output logic                     acc_valid,
  output logic [PRIO_W+SRC_W-1:0]  acc_word,
  input  logic                     cpu_eoi_we,
  input  logic [PRIO_W+SRC_W-1:0]  cpu_eoi_word,
  input  logic                     cpu_prio_we,
  input  logic [PRIO_W-1:0]        cpu_prio_val,
  input  logic                     cpu_ipi_we,
  input  logic [PRIO_W-1:0]        cpu_ipi_val,
  output logic [PRIO_W+SRC_W-1:0]  poll_word,
  output logic [PRIO_W-1:0]        poll_ipi,
  input  logic                     req_valid,
  input  logic [SRC_W-1:0]         req_src,
  input  logic [PRIO_W-1:0]        req_prio,
  output logic                     rej_valid,
  output logic [SRC_W-1:0]         rej_src,
  output logic                     eoi_valid,
  output logic [SRC_W-1:0]         eoi_src,
  output logic                     resend_req,
  output logic                     irq_out
);
  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [SRC_W-1:0]  IPI_ID   = SRC_W'(IPI_SRC);
  localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ipc_op_e           op;
  logic [SRC_W-1:0]  eff_src;
  logic [PRIO_W-1:0] eff_prio;

  ipc_arb #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rst_n(rst_int_n),
    .cpu_accept(cpu_accept), .cpu_eoi_we(cpu_eoi_we),
    .cpu_prio_we(cpu_prio_we), .cpu_ipi_we(cpu_ipi_we),
    .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
    .op(op), .eff_src(eff_src), .eff_prio(eff_prio)
  );

  // architectural state
  logic [PRIO_W-1:0] cppr_q, cppr_d;
  logic [SRC_W-1:0]  xsrc_q, xsrc_d;
  logic [PRIO_W-1:0] pend_q, pend_d;
  logic [PRIO_W-1:0] ipi_q, ipi_d;
  logic              ext_q, ext_d;
  logic              irq_q, irq_d;
  logic              st_en;
  // output pulses
  logic              acc_vld_q, acc_vld_d;
  logic [WORD_W-1:0] acc_word_q, acc_word_d;
  logic              rej_vld_q, rej_vld_d;
  logic [SRC_W-1:0]  rej_src_q, rej_src_d;
  logic              eoi_vld_q, eoi_vld_d;
  logic [SRC_W-1:0]  eoi_src_q, eoi_src_d;
  logic              resend_q, resend_d;

  logic              pend_nz;
  logic [PRIO_W-1:0] eoi_prio;
  logic [PRIO_W-1:0] ipi_eff, cppr_new;
  logic              resend_now, ipi_chk, ipi_take;

  assign pend_nz  = xsrc_q != '0;
  assign eoi_prio = cpu_eoi_word[WORD_W-1:SRC_W];

  always_comb begin
    ipi_eff  = (op == OP_IPI) ? cpu_ipi_val : ipi_q;
    cppr_new = cppr_q;
    if (op == OP_EOI)       cppr_new = eoi_prio;
    else if (op == OP_PRIO) cppr_new = cpu_prio_val;
    resend_now = !pend_nz &&
                 ((op == OP_EOI) || ((op == OP_PRIO) && (cpu_prio_val >= cppr_q)));
    ipi_chk    = (op == OP_IPI) || resend_now;
  end

  ipc_ipi_eval #(.PRIO_W(PRIO_W)) u_ipi (
    .check_en(ipi_chk), .pend_nz(pend_nz), .pend_prio(pend_q),
    .ipi_prio(ipi_eff), .cur_prio(cppr_new), .ipi_take(ipi_take)
  );

  // next state
  always_comb begin
    cppr_d     = cppr_q;
    xsrc_d     = xsrc_q;
    pend_d     = pend_q;
    ipi_d      = ipi_q;
    ext_d      = ext_q;
    irq_d      = irq_q;
    acc_vld_d  = 1'b0;
    acc_word_d = acc_word_q;
    rej_vld_d  = 1'b0;
    rej_src_d  = rej_src_q;
    eoi_vld_d  = 1'b0;
    eoi_src_d  = eoi_src_q;
    resend_d   = resend_now;
    st_en      = op != OP_NONE;

    unique case (op)
      OP_ACCEPT: begin
        acc_vld_d  = 1'b1;
        acc_word_d = {cppr_q, xsrc_q};
        cppr_d     = pend_q;
        xsrc_d     = '0;
        pend_d     = PRIO_OFF;
        ext_d      = 1'b0;
        irq_d      = 1'b0;
      end
      OP_EOI: begin
        cppr_d    = eoi_prio;
        eoi_vld_d = 1'b1;
        eoi_src_d = cpu_eoi_word[SRC_W-1:0];
      end
      OP_PRIO: begin
        cppr_d = cpu_prio_val;
        if ((cpu_prio_val < cppr_q) && pend_nz && (cpu_prio_val <= pend_q)) begin
          xsrc_d = '0;
          pend_d = PRIO_OFF;
          irq_d  = 1'b0;
          ext_d  = 1'b0;
          if (ext_q) begin
            rej_vld_d = 1'b1;
            rej_src_d = xsrc_q;
          end
        end
      end
      OP_IPI: begin
        ipi_d = cpu_ipi_val;
      end
      OP_REQ: begin
        if ((eff_prio >= cppr_q) || (pend_nz && (pend_q <= eff_prio))) begin
          rej_vld_d = 1'b1;
          rej_src_d = eff_src;
        end else begin
          if (pend_nz && ext_q) begin
            rej_vld_d = 1'b1;
            rej_src_d = xsrc_q;
          end
          xsrc_d = eff_src;
          pend_d = eff_prio;
          ext_d  = 1'b1;
          irq_d  = 1'b1;
        end
      end
      default: ;
    endcase

    if (ipi_take) begin
      if (pend_nz && ext_q) begin
        rej_vld_d = 1'b1;
        rej_src_d = xsrc_q;
      end
      xsrc_d = IPI_ID;
      pend_d = ipi_eff;
      ext_d  = 1'b0;
      irq_d  = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cppr_q <= '0;
      xsrc_q <= '0;
      pend_q <= PRIO_OFF;
      ipi_q  <= PRIO_OFF;
      ext_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else if (st_en) begin
      cppr_q <= cppr_d;
      xsrc_q <= xsrc_d;
      pend_q <= pend_d;
      ipi_q  <= ipi_d;
      ext_q  <= ext_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc_vld_q  <= 1'b0;
      acc_word_q <= '0;
      rej_vld_q  <= 1'b0;
      rej_src_q  <= '0;
      eoi_vld_q  <= 1'b0;
      eoi_src_q  <= '0;
      resend_q   <= 1'b0;
    end else begin
      acc_vld_q <= acc_vld_d;
      rej_vld_q <= rej_vld_d;
      eoi_vld_q <= eoi_vld_d;
      resend_q  <= resend_d;
      if (acc_vld_d) acc_word_q <= acc_word_d;
      if (rej_vld_d) rej_src_q  <= rej_src_d;
      if (eoi_vld_d) eoi_src_q  <= eoi_src_d;
    end
  end

  assign acc_valid  = acc_vld_q;
  assign acc_word   = acc_word_q;
  assign rej_valid  = rej_vld_q;
  assign rej_src    = rej_src_q;
  assign eoi_valid  = eoi_vld_q;
  assign eoi_src    = eoi_src_q;
  assign resend_req = resend_q;
  assign irq_out    = irq_q;
  assign poll_word  = {cppr_q, xsrc_q};
  assign poll_ipi   = ipi_q;
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cpu_accept,
  input logic                    acc_valid,
  input logic                    cpu_eoi_we,
  input logic [PRIO_W+SRC_W-1:0] cpu_eoi_word,
  input logic                    cpu_prio_we,
  input logic [PRIO_W-1:0]       cpu_prio_val,
  input logic                    cpu_ipi_we,
  input logic [PRIO_W-1:0]       cpu_ipi_val,
  input logic [PRIO_W+SRC_W-1:0] poll_word,
  input logic [PRIO_W-1:0]       poll_ipi,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src,
  input logic                    irq_out
);
  localparam int WORD_W = PRIO_W + SRC_W;

  assert_irq_tracks_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (poll_word[SRC_W-1:0] != '0));

  assert_accept_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_accept |=> (acc_valid && !irq_out && (poll_word[SRC_W-1:0] == '0)));

  assert_eoi_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_eoi_we && !cpu_accept) |=>
      (eoi_valid && (eoi_src == $past(cpu_eoi_word[SRC_W-1:0])) &&
       (poll_word[WORD_W-1:SRC_W] == $past(cpu_eoi_word[WORD_W-1:SRC_W]))));

  assert_prio_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_prio_we && !cpu_accept && !cpu_eoi_we) |=>
      (poll_word[WORD_W-1:SRC_W] == $past(cpu_prio_val)));

  assert_ipi_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ipi_we && !cpu_accept && !cpu_eoi_we && !cpu_prio_we) |=>
      (poll_ipi == $past(cpu_ipi_val)));

  assert_accept_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_accept |=> (poll_ipi == $past(poll_ipi)));
endmodule

bind intr_presenter ipc_checker #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_accept(cpu_accept), .acc_valid(acc_valid),
  .cpu_eoi_we(cpu_eoi_we), .cpu_eoi_word(cpu_eoi_word),
  .cpu_prio_we(cpu_prio_we), .cpu_prio_val(cpu_prio_val),
  .cpu_ipi_we(cpu_ipi_we), .cpu_ipi_val(cpu_ipi_val),
  .poll_word(poll_word), .poll_ipi(poll_ipi),
  .eoi_valid(eoi_valid), .eoi_src(eoi_src), .irq_out(irq_out)
);

// File: tb/intr_presenter_tb.sv
module intr_presenter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_accept, cpu_eoi_we, cpu_prio_we, cpu_ipi_we, req_valid;
  logic [31:0] cpu_eoi_word;
  logic [7:0]  cpu_prio_val, cpu_ipi_val, req_prio;
  logic [23:0] req_src;
  logic        acc_valid, rej_valid, eoi_valid, resend_req, irq_out;
  logic [31:0] acc_word, poll_word;
  logic [7:0]  poll_ipi;
  logic [23:0] rej_src, eoi_src;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_presenter u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_accept(cpu_accept), .acc_valid(acc_valid), .acc_word(acc_word),
    .cpu_eoi_we(cpu_eoi_we), .cpu_eoi_word(cpu_eoi_word),
    .cpu_prio_we(cpu_prio_we), .cpu_prio_val(cpu_prio_val),
    .cpu_ipi_we(cpu_ipi_we), .cpu_ipi_val(cpu_ipi_val),
    .poll_word(poll_word), .poll_ipi(poll_ipi),
    .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
    .rej_valid(rej_valid), .rej_src(rej_src),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src),
    .resend_req(resend_req), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_in();
    cpu_accept = 0; cpu_eoi_we = 0; cpu_prio_we = 0; cpu_ipi_we = 0; req_valid = 0;
  endtask

  task automatic op_req(input logic [23:0] s, input logic [7:0] p);
    req_valid = 1; req_src = s; req_prio = p; step(); clear_in();
  endtask
  task automatic op_prio(input logic [7:0] v);
    cpu_prio_we = 1; cpu_prio_val = v; step(); clear_in();
  endtask
  task automatic op_ipi(input logic [7:0] v);
    cpu_ipi_we = 1; cpu_ipi_val = v; step(); clear_in();
  endtask
  task automatic op_accept();
    cpu_accept = 1; step(); clear_in();
  endtask
  task automatic op_eoi(input logic [31:0] w);
    cpu_eoi_we = 1; cpu_eoi_word = w; step(); clear_in();
  endtask

  task automatic t_reset();
    chk("R2 poll_word", poll_word, 32'h0);
    chk("R2 poll_ipi", poll_ipi, 32'hFF);
    chk("R2 irq_out", irq_out, 0);
    chk("R2 pulses", {acc_valid, rej_valid, eoi_valid, resend_req}, 0);
  endtask

  task automatic t_basic_requests();
    op_req(24'h8, 8'h0);
    chk("R3 reject prio>=cppr valid", rej_valid, 1);
    chk("R3 reject src", rej_src, 24'h8);
    chk("R3 state unchanged", poll_word, 32'h0);
    op_prio(8'hFF);
    chk("R8 resend on raise", resend_req, 1);
    chk("R8 no ipi when ipi==cppr", irq_out, 0);
    op_req(24'h10, 8'h5);
    chk("R4 pending loaded", poll_word, 32'hFF000010);
    chk("R12 irq high", irq_out, 1);
    chk("R4 no reject", rej_valid, 0);
    op_req(24'h11, 8'h5);
    chk("R3 equal prio rejected", {rej_valid, 7'd0, rej_src}, {1'b1, 7'd0, 24'h11});
    chk("R3 state kept", poll_word, 32'hFF000010);
    op_req(24'h12, 8'h3);
    chk("R4 preempt rejects old", {rej_valid, 7'd0, rej_src}, {1'b1, 7'd0, 24'h10});
    chk("R4 new pending", poll_word, 32'hFF000012);
  endtask

  task automatic t_accept_eoi();
    op_accept();
    chk("R6 acc_valid", acc_valid, 1);
    chk("R6 acc_word", acc_word, 32'hFF000012);
    chk("R6 state after", poll_word, 32'h03000000);
    chk("R6 irq dropped", irq_out, 0);
    op_eoi(32'hFF000012);
    chk("R9 eoi pulse", eoi_valid, 1);
    chk("R9 eoi src", eoi_src, 24'h12);
    chk("R9 prio restored", poll_word, 32'hFF000000);
    chk("R9 resend", resend_req, 1);
  endtask

  task automatic t_ipi();
    op_ipi(8'h04);
    chk("R5 ipi pending", poll_word, 32'hFF000002);
    chk("R5 ipi irq", irq_out, 1);
    chk("R5 poll_ipi", poll_ipi, 32'h04);
    op_req(24'h20, 8'h2);
    chk("R5 preempted ipi not rejected", rej_valid, 0);
    chk("R4 ext pending over ipi", poll_word, 32'hFF000020);
    op_ipi(8'h06);
    chk("R5 blocked ipi no change", poll_word, 32'hFF000020);
    chk("R5 blocked ipi stored", poll_ipi, 32'h06);
    chk("R1 poll no side effect", rej_valid, 0);
    op_ipi(8'h01);
    chk("R5 ipi rejects ext", {rej_valid, 7'd0, rej_src}, {1'b1, 7'd0, 24'h20});
    chk("R5 ipi at 1", poll_word, 32'hFF000002);
  endtask

  task automatic t_cppr();
    op_prio(8'h01);
    chk("R7 clear pending", poll_word, 32'h01000000);
    chk("R7 irq low", irq_out, 0);
    chk("R7 ipi not rejected", rej_valid, 0);
    op_prio(8'h80);
    chk("R8 resend", resend_req, 1);
    chk("R8 ipi reinstated", poll_word, 32'h80000002);
    chk("R12 irq with ipi", irq_out, 1);
    op_accept();
    chk("R6 accept ipi", acc_word, 32'h80000002);
    op_ipi(8'hFF);
    op_eoi(32'hFF000002);
    chk("R9 eoi ipi src", eoi_src, 24'h2);
    chk("R9 no ipi when ipi==cppr", poll_word, 32'hFF000000);
    op_req(24'h30, 8'h40);
    chk("R4 ext loaded", poll_word, 32'hFF000030);
    op_prio(8'h20);
    chk("R7 ext rejected", {rej_valid, 7'd0, rej_src}, {1'b1, 7'd0, 24'h30});
    chk("R7 state", poll_word, 32'h20000000);
    chk("R7 irq low ext", irq_out, 0);
  endtask

  task automatic t_arbitration();
    cpu_accept = 1; cpu_ipi_we = 1; cpu_ipi_val = 8'h05; step(); clear_in();
    chk("R10 accept wins word", acc_word, 32'h20000000);
    chk("R10 ipi write ignored", poll_ipi, 32'hFF);
    chk("R10 cppr from pending", poll_word, 32'hFF000000);
    cpu_prio_we = 1; cpu_prio_val = 8'hFF;
    req_valid = 1; req_src = 24'h40; req_prio = 8'h07;
    step(); clear_in();
    chk("R11 held not yet", poll_word, 32'hFF000000);
    chk("R8 resend on equal", resend_req, 1);
    step();
    chk("R11 held request applied", poll_word, 32'hFF000040);
    chk("R11 irq", irq_out, 1);
    step();
    chk("R1 poll stable", poll_word, 32'hFF000040);
    chk("R1 no pulses idle", {acc_valid, rej_valid, eoi_valid, resend_req}, 0);
  endtask

  initial begin
    clear_in();
    cpu_eoi_word = '0; cpu_prio_val = '0; cpu_ipi_val = '0;
    req_src = '0; req_prio = '0;
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    repeat (3) step();
    t_reset();
    t_basic_requests();
    t_accept_eoi();
    t_ipi();
    t_cppr();
    t_arbitration();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule